// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. A host starts a conversion by pulling chip select and write low together. The block raises a busy status and steps a trial word down from the most significant bit. It compares each trial against a single-bit comparator input and keeps or drops that bit. When the last bit is resolved it drops status and latches the finished word. A mode input selects offset-binary or two's-complement coding.

Every finished word is also sent out as a serial stream: sixteen falling edges of a strobe, with the data bit set up for each edge, MSB first. This lets a plain shift register behind an isolation barrier rebuild the word. A synchronous reset command arms the block after power-up, clears its registers and aborts any conversion in progress.

Each bit uses two clocks: one for the trial level to settle and one to sample the comparator. A conversion therefore lasts 32 cycles. If status is wired back to the write strobe and chip select is held low, the block converts back to back.

Top module: `sar_seq`

## Requirements
- R1: After the asynchronous reset rst_ni, status_o is high, data_o is 0, done_o is 0, sstrobe_o is 1 and sdata_o is 0. Start requests are ignored until reset_i has been pulsed.
- R2: A cycle with reset_i high arms the block. In the following cycle status_o is 0, trial_o is 0, data_o is 0 and sstrobe_o is 1. Any conversion in progress is abandoned and produces no done_o pulse.
- R3: With status_o low, a clock edge that samples cs_ni=0 and wr_ni=0 starts a conversion. status_o is high from that edge on and trial_o reads 0x8000.
- R4: While status_o is high, the values on cs_ni and wr_ni change neither the result nor the length of the conversion.
- R5: status_o stays high for exactly 32 cycles: two cycles per bit, from bit 15 down to bit 0.
- R6: Bit k of the result is 1 exactly when comp_i is 1 on the second cycle that trial bit k is presented. A comparator that reports "input at or above trial" therefore yields the largest code not above the input.
- R7: If fmt_twos_i is 0, data_o is the offset-binary code (mid-scale input gives 0x8000). If fmt_twos_i is 1, bit 15 is inverted (mid-scale gives 0x0000).
- R8: done_o is high for exactly one cycle, the cycle in which status_o first reads low. data_o changes only at that edge or on a reset.
- R9: After each done_o the strobe, which idles high, gives exactly 16 falling edges. At falling edge n, sdata_o carries result bit 16-n. sdata_o changes only when the strobe rises, and the strobe is high again after the 16th edge.
- R10: With cs_ni held low and wr_ni driven from status_o, conversions run back to back, with done_o pulses 33 cycles apart.
- R11: cs_ni low alone, or wr_ni low alone, does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| reset_i | input | 1 | Synchronous reset command; arms the block and aborts a conversion |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe |
| comp_i | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| fmt_twos_i | input | 1 | 1 selects two's-complement coding |
| status_o | output | 1 | High while converting or while not yet armed |
| trial_o | output | 16 | Trial word driving the DAC |
| data_o | output | 16 | Latched coded result |
| done_o | output | 1 | One-cycle pulse when a result is latched |
| sstrobe_o | output | 1 | Serial data strobe, idles high |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The assertions check on every cycle that status can only rise after a start request and that a new conversion always begins with the trial word at 0x8000. They also check that done coincides with every falling status edge not caused by reset and lasts one cycle. The latched word must stay put between done pulses, and serial data must hold still while the strobe is low. The bench scenarios show what a property cannot: the resolved value for a set of comparator thresholds in both codings, the exact 32-cycle status length, the serial stream rebuilding the word, the ignored requests before arming and during a conversion, the abort, and the 33-cycle spacing of continuous conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DECIDE
  } conv_state_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_i,
  input  logic             start_i,
  input  logic             comp_i,
  output logic             busy_o,
  output logic             armed_o,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             fin_o
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  conv_state_e      state_q;
  logic [WIDTH-1:0] sar_q;
  logic [IDX_W-1:0] idx_q;
  logic             armed_q;
  logic [WIDTH-1:0] bit_mask;
  logic [WIDTH-1:0] decided;

  assign bit_mask = ONE << idx_q;
  // trial bit dropped when comparator says input is below trial
  assign decided  = comp_i ? sar_q : (sar_q & ~bit_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (reset_i) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && armed_q) begin
            sar_q   <= ONE << (WIDTH - 1);
            idx_q   <= IDX_W'(WIDTH - 1);
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: state_q <= ST_DECIDE;
        ST_DECIDE: begin
          if (idx_q == '0) begin
            sar_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            sar_q   <= decided | (bit_mask >> 1);
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign armed_o  = armed_q;
  assign trial_o  = sar_q;
  assign result_o = decided;
  assign fin_o    = (state_q == ST_DECIDE) && (idx_q == '0) && !reset_i;
endmodule

// File: rtl/sar_coder.sv
module sar_coder #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_i,
  input  logic             load_i,
  input  logic             fmt_twos_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] data_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] data_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else if (reset_i) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_i;
      if (load_i) data_q <= fmt_twos_i ? (word_i ^ MSB_MASK) : word_i;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
endmodule

// File: rtl/sar_serial.sv
module sar_serial #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             strobe_o,
  output logic             sdata_o
);
  localparam int STEPS = 2 * WIDTH;
  localparam int CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [WIDTH-1:0] sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      act_q    <= 1'b0;
      strobe_q <= 1'b1;
    end else if (reset_i) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      act_q    <= 1'b0;
      strobe_q <= 1'b1;
    end else if (load_i) begin
      sreg_q   <= word_i;
      cnt_q    <= '0;
      act_q    <= 1'b1;
      strobe_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_q    <= 1'b0;
        strobe_q <= 1'b1;
        sreg_q   <= '0;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        strobe_q <= ~strobe_q;
        // advance data only on the rising step
        if (!strobe_q) sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
      end
    end
  end

  assign strobe_o = strobe_q;
  assign sdata_o  = sreg_q[WIDTH-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_i,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             comp_i,
  input  logic             fmt_twos_i,
  output logic             status_o,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] data_o,
  output logic             done_o,
  output logic             sstrobe_o,
  output logic             sdata_o
);
  logic             start_req;
  logic             busy;
  logic             armed;
  logic             fin;
  logic [WIDTH-1:0] result;
  logic [WIDTH-1:0] latched;

  assign start_req = !cs_ni && !wr_ni;

  sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reset_i (reset_i),
    .start_i (start_req),
    .comp_i  (comp_i),
    .busy_o  (busy),
    .armed_o (armed),
    .trial_o (trial_o),
    .result_o(result),
    .fin_o   (fin)
  );

  sar_coder #(.WIDTH(WIDTH)) u_coder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reset_i   (reset_i),
    .load_i    (fin),
    .fmt_twos_i(fmt_twos_i),
    .word_i    (result),
    .data_o    (latched),
    .done_o    (done_o)
  );

  sar_serial #(.WIDTH(WIDTH)) u_serial (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reset_i (reset_i),
    .load_i  (fin),
    .word_i  (fmt_twos_i ? {~result[WIDTH-1], result[WIDTH-2:0]} : result),
    .strobe_o(sstrobe_o),
    .sdata_o (sdata_o)
  );

  assign data_o   = latched;
  // unarmed block reports busy so nothing can start before reset_i
  assign status_o = busy || !armed;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reset_i,
  input logic             cs_ni,
  input logic             wr_ni,
  input logic             status_o,
  input logic [WIDTH-1:0] trial_o,
  input logic [WIDTH-1:0] data_o,
  input logic             done_o,
  input logic             sstrobe_o,
  input logic             sdata_o
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  assert_start_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(!cs_ni && !wr_ni));

  assert_first_trial_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> trial_o == TOP);

  assert_reset_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> (!status_o && trial_o == '0 && data_o == '0 && sstrobe_o && !done_o));

  assert_done_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(status_o) && !$past(reset_i)) |-> done_o);

  assert_done_with_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(status_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(reset_i)) |-> $stable(data_o));

  assert_sdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sstrobe_o |-> $stable(sdata_o));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .reset_i  (reset_i),
  .cs_ni    (cs_ni),
  .wr_ni    (wr_ni),
  .status_o (status_o),
  .trial_o  (trial_o),
  .data_o   (data_o),
  .done_o   (done_o),
  .sstrobe_o(sstrobe_o),
  .sdata_o  (sdata_o)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_cmd = 1'b0;
  logic        cs_drv = 1'b1;
  logic        wr_drv = 1'b1;
  logic        cont = 1'b0;
  logic        fmt = 1'b0;
  logic [15:0] vin = 16'h0;
  logic        cs_n, wr_n, comp;
  logic        status, done, sstrobe, sdata;
  logic [15:0] trial, data;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign cs_n = cont ? 1'b0 : cs_drv;
  assign wr_n = cont ? status : wr_drv;
  assign comp = (trial <= vin);  // comparator/DAC stand-in

  sar_seq u_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .reset_i(reset_cmd), .cs_ni(cs_n), .wr_ni(wr_n),
    .comp_i(comp), .fmt_twos_i(fmt), .status_o(status), .trial_o(trial),
    .data_o(data), .done_o(done), .sstrobe_o(sstrobe), .sdata_o(sdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: power-up state, start ignored until reset command
  task automatic t_powerup();
    chk(status == 1'b1, "R1 status", 32'(status), 1);
    chk(data == 16'h0 && done == 1'b0, "R1 data/done", {data, 15'h0, done}, 0);
    chk(sstrobe == 1'b1 && sdata == 1'b0, "R1 serial idle", {sstrobe, sdata}, 2);
    cs_drv = 0; wr_drv = 0;
    idle(3);
    cs_drv = 1; wr_drv = 1;
    idle(1);
    chk(status == 1'b1 && trial == 16'h0, "R1 start ignored", {status, trial}, 32'h10000);
    reset_cmd = 1;
    idle(1);
    reset_cmd = 0;
    chk(status == 1'b0, "R2 armed status low", 32'(status), 0);
  endtask

  // R3 R5 R6 R7 R8 R9 (R4 when inject set)
  task automatic t_conv(input logic [15:0] v, input logic f, input bit inject);
    logic [15:0] exp;
    logic [15:0] ser;
    int hi;
    int falls;
    logic prev;
    vin = v; fmt = f;
    exp = f ? (v ^ 16'h8000) : v;
    cs_drv = 0; wr_drv = 0;
    idle(1);
    cs_drv = 1; wr_drv = 1;
    chk(status == 1'b1, "R3 status rises", 32'(status), 1);
    chk(trial == 16'h8000, "R3 first trial", 32'(trial), 32'h8000);
    hi = 1;
    while (status && hi < 100) begin
      if (inject && hi == 10) begin cs_drv = 0; wr_drv = 0; end
      if (inject && hi == 20) begin cs_drv = 1; wr_drv = 1; end
      idle(1);
      if (status) hi++;
    end
    chk(hi == 32, inject ? "R4 length unchanged" : "R5 status length", 32'(hi), 32);
    chk(done == 1'b1, "R8 done with fall", 32'(done), 1);
    chk(data == exp, f ? "R7 twos result" : "R6 R7 offset result", 32'(data), 32'(exp));
    ser = '0; falls = 0;
    for (int i = 0; i < 34; i++) begin
      prev = sstrobe;
      idle(1);
      if (i == 0) chk(done == 1'b0, "R8 done one cycle", 32'(done), 0);
      if (prev && !sstrobe) begin
        falls++;
        ser = {ser[14:0], sdata};
      end
    end
    chk(falls == 16, "R9 fall count", 32'(falls), 16);
    chk(ser == exp, "R9 serial word", 32'(ser), 32'(exp));
    chk(sstrobe == 1'b1, "R9 strobe idle high", 32'(sstrobe), 1);
    chk(data == exp, "R8 data held", 32'(data), 32'(exp));
  endtask

  // R11: one strobe alone does nothing
  task automatic t_half_req();
    cs_drv = 0; idle(3); cs_drv = 1;
    chk(status == 1'b0 && done == 1'b0, "R11 cs alone", {status, done}, 0);
    wr_drv = 0; idle(3); wr_drv = 1;
    idle(1);
    chk(status == 1'b0 && trial == 16'h0, "R11 wr alone", {status, trial}, 0);
  endtask

  // R2: abort mid-conversion
  task automatic t_abort();
    int seen;
    vin = 16'h7777; fmt = 0;
    cs_drv = 0; wr_drv = 0; idle(1); cs_drv = 1; wr_drv = 1;
    idle(10);
    reset_cmd = 1; idle(1); reset_cmd = 0;
    chk(status == 1'b0 && trial == 16'h0, "R2 abort status/trial", {status, trial}, 0);
    chk(data == 16'h0 && sstrobe == 1'b1, "R2 abort data/strobe", {data, sstrobe}, 1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      if (done || status) seen++;
    end
    chk(seen == 0, "R2 no late done", 32'(seen), 0);
  endtask

  // R10: continuous conversion with status fed back
  task automatic t_continuous();
    int t_done[4];
    int nd;
    vin = 16'h4E21; fmt = 0;
    nd = 0;
    cont = 1;
    for (int i = 0; i < 120; i++) begin
      idle(1);
      if (done && nd < 4) begin
        t_done[nd] = i;
        chk(data == 16'h4E21, "R10 continuous data", 32'(data), 32'h4E21);
        nd++;
      end
    end
    cont = 0;
    chk(nd >= 3, "R10 done count", 32'(nd), 3);
    if (nd >= 3) begin
      chk(t_done[1] - t_done[0] == 33, "R10 spacing", 32'(t_done[1] - t_done[0]), 33);
      chk(t_done[2] - t_done[1] == 33, "R10 spacing", 32'(t_done[2] - t_done[1]), 33);
    end
    while (status) idle(1);
    idle(40);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_powerup();
    t_conv(16'h8000, 0, 0);
    t_conv(16'h8000, 1, 0);
    t_conv(16'hFFFF, 0, 0);
    t_conv(16'h0000, 0, 0);
    t_conv(16'h1234, 1, 0);
    t_conv(16'hA5C3, 0, 0);
    t_conv(16'h3C3C, 0, 1);
    t_half_req();
    t_abort();
    t_continuous();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule